// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

The block moves a run of 32-bit words from a source address to a destination address over a simple request/acknowledge memory port. Software sets it up through a small register window. The window holds a source address, a destination address, an address mode for each side and a byte count. A write to a shared command register then launches the copy. Each beat reads one word at the source and writes it to the destination. After every beat, each address moves up by four, moves down by four, or stays put. The fixed mode lets one end of the copy be a FIFO-style peripheral.

The byte count in the window counts down live, so a read of it at any point returns the bytes still to be moved. When the copy ends, a completion flag is latched and the interrupt output rises. Software can also abort the channel at any time. The beat in flight is finished, the channel goes idle, and an abort flag is latched together with the completion flag.

The parameter `CH_IDX` places the engine on the shared register map. It selects which command bit belongs to this channel, and it sets the channel window base to 0x100 + 0x40 × `CH_IDX`.

Top module: `dma_xfer_engine`

## Requirements
- R1: A register write to offset 0x000 with bit `CH_IDX` set and bit 31 clear starts an idle channel whose size is non-zero. Each beat then reads the word at the source address and writes that same word to the destination address.
- R2: A start command has no effect while the channel is busy. A command write whose bit `CH_IDX` is clear has no effect, whether or not bit 31 is set.
- R3: The mode registers sit at window offsets 0x20 (source) and 0x24 (destination), with the mode in bits [5:4]. Code 0 adds 4 to the address after each beat, code 1 subtracts 4, and codes 2 and 3 leave the address unchanged.
- R4: The size register at window offset 0x30 reads back the bytes still to be moved. It drops by 4 when each beat's write is acknowledged, and it reads 0 after a normal completion.
- R5: The source address register (window offset 0x28) and the destination address register (window offset 0x2C) read back the current, advancing addresses.
- R6: Register writes to the mode, address and size registers are ignored while the channel is busy.
- R7: The event register sits at window offset 0x14. Bit 1 is the completion flag and bit 13 is the abort flag. The completion flag is set when the last beat finishes. `irq_o` is high while either flag is set. Writing 1 to a bit clears that flag, and a new setting event in the same cycle wins over the clear.
- R8: A command write with bits 31 and `CH_IDX` both set aborts a busy channel. The beat in flight completes, the channel goes idle, and both the abort flag and the completion flag are set.
- R9: An abort command to an idle channel sets the abort flag and the completion flag on the next clock edge.
- R10: A start with size 0 issues no memory request and sets the completion flag on the next clock edge.
- R11: `mem_req_o` is high exactly while the channel is busy. A request holds its address and direction stable until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | Register access is a write |
| reg_addr_i | input | RAW | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | DW | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge; carries read data for reads |
| mem_rdata_i | input | DW | Memory read data |
| irq_o | output | 1 | Event flag pending |

## Verification
The bench builds the engine with `CH_IDX` = 2, so the window sits at 0x180 and command bit 2 belongs to it. Commands aimed at bit 0 can then be shown to do nothing, and the window decode is checked away from offset 0x100. The size width is set to 16 bits, narrower than the 32-bit address and data, to exercise zero-extension on read-back. Memory latency is changed between copies, which stretches beats long enough to read the live count, issue ignored writes and land an abort in mid-beat. A region of memory acts as a FIFO and brings the fixed-address modes within reach.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [1:0] {
    MODE_INC = 2'd0,
    MODE_DEC = 2'd1,
    MODE_FIX = 2'd2,
    MODE_RSV = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR
  } seq_state_e;

  localparam int unsigned WIN_BASE   = 'h100;
  localparam int unsigned WIN_STRIDE = 'h40;
  localparam int unsigned OFS_EVT    = 'h14;
  localparam int unsigned OFS_SMODE  = 'h20;
  localparam int unsigned OFS_DMODE  = 'h24;
  localparam int unsigned OFS_SADDR  = 'h28;
  localparam int unsigned OFS_DADDR  = 'h2C;
  localparam int unsigned OFS_SIZE   = 'h30;
  localparam int unsigned CMD_ABORT_BIT = 31;
  localparam int unsigned EVT_DONE_BIT  = 1;
  localparam int unsigned EVT_ABORT_BIT = 13;
  localparam int unsigned MODE_LSB      = 4;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_xfer_pkg::*;
#(
  parameter int unsigned RAW    = 12,
  parameter int unsigned CH_IDX = 0
) (
  input  logic           valid_i,
  input  logic           write_i,
  input  logic [RAW-1:0] addr_i,
  input  logic [31:0]    wdata_i,
  input  logic           busy_i,
  output logic           start_o,
  output logic           abort_o,
  output logic [1:0]     mode_we_o,
  output logic [1:0]     addr_we_o,
  output logic           size_we_o,
  output logic [1:0]     clr_o
);
  localparam int unsigned WIN = WIN_BASE + WIN_STRIDE * CH_IDX;

  logic wr, cmd_hit, cfg_ok, unused_wdata;

  assign wr      = valid_i && write_i;
  assign cmd_hit = wr && (addr_i == '0) && wdata_i[CH_IDX];
  assign cfg_ok  = wr && !busy_i;

  assign start_o = cmd_hit && !wdata_i[CMD_ABORT_BIT];
  assign abort_o = cmd_hit &&  wdata_i[CMD_ABORT_BIT];

  assign mode_we_o[0] = cfg_ok && (addr_i == RAW'(WIN + OFS_SMODE));
  assign mode_we_o[1] = cfg_ok && (addr_i == RAW'(WIN + OFS_DMODE));
  assign addr_we_o[0] = cfg_ok && (addr_i == RAW'(WIN + OFS_SADDR));
  assign addr_we_o[1] = cfg_ok && (addr_i == RAW'(WIN + OFS_DADDR));
  assign size_we_o    = cfg_ok && (addr_i == RAW'(WIN + OFS_SIZE));

  // event clear is allowed at any time
  assign clr_o[0] = wr && (addr_i == RAW'(WIN + OFS_EVT)) && wdata_i[EVT_DONE_BIT];
  assign clr_o[1] = wr && (addr_i == RAW'(WIN + OFS_EVT)) && wdata_i[EVT_ABORT_BIT];

  assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_xfer_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned BEAT_B = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_we_i,
  input  logic [1:0]    mode_i,
  input  logic          addr_we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          step_i,
  output logic [1:0]    mode_o,
  output logic [AW-1:0] addr_o
);
  addr_mode_e    mode_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_INC;
      addr_q <= '0;
    end else begin
      if (mode_we_i) mode_q <= addr_mode_e'(mode_i);
      if (addr_we_i) begin
        addr_q <= addr_i;
      end else if (step_i) begin
        unique case (mode_q)
          MODE_INC: addr_q <= addr_q + AW'(BEAT_B);
          MODE_DEC: addr_q <= addr_q - AW'(BEAT_B);
          default:  addr_q <= addr_q;
        endcase
      end
    end
  end

  assign mode_o = mode_q;
  assign addr_o = addr_q;

  assert_fixed_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !addr_we_i && mode_q[1]) |=> $stable(addr_o));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_xfer_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic          size_we_i,
  input  logic [SW-1:0] size_i,
  input  logic [1:0]    clr_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          step_o,
  output logic          busy_o,
  output logic [SW-1:0] size_o,
  output logic          evt_done_o,
  output logic          evt_abort_o
);
  localparam int unsigned BEAT_B = DW / 8;

  seq_state_e    state_q, state_d;
  logic [SW-1:0] size_q;
  logic [DW-1:0] buf_q;
  logic          pend_q, done_q, abt_q;
  logic          idle, last_beat, beat_end, stop, set_done, set_abt;

  assign idle      = (state_q == ST_IDLE);
  assign last_beat = (size_q <= SW'(BEAT_B));
  assign beat_end  = (state_q == ST_WR) && mem_ack_i;
  assign stop      = beat_end && (last_beat || pend_q || abort_i);
  assign set_done  = stop || (idle && ((start_i && size_q == '0) || abort_i));
  assign set_abt   = (stop && (pend_q || abort_i)) || (idle && abort_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i && size_q != '0) state_d = ST_RD;
      ST_RD:   if (mem_ack_i) state_d = ST_WR;
      ST_WR:   if (mem_ack_i) state_d = stop ? ST_IDLE : ST_RD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      size_q  <= '0;
      buf_q   <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      abt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (size_we_i)     size_q <= size_i;
      else if (beat_end) size_q <= last_beat ? '0 : size_q - SW'(BEAT_B);
      if (state_q == ST_RD && mem_ack_i) buf_q <= mem_rdata_i;
      pend_q <= !idle && !stop && (pend_q || abort_i);
      if (set_done)      done_q <= 1'b1;
      else if (clr_i[0]) done_q <= 1'b0;
      if (set_abt)       abt_q  <= 1'b1;
      else if (clr_i[1]) abt_q  <= 1'b0;
    end
  end

  assign mem_req_o   = !idle;
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = mem_we_o ? dst_addr_i : src_addr_i;
  assign mem_wdata_o = buf_q;
  assign step_o      = beat_end;
  assign busy_o      = !idle;
  assign size_o      = size_q;
  assign evt_done_o  = done_q;
  assign evt_abort_o = abt_q;

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  assert_size_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_end |=> (size_q < $past(size_q)));
  assert_abort_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && beat_end) |=> (!mem_req_o && evt_abort_o && evt_done_o));
  assert_idle_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && abort_i) |=> (evt_abort_o && evt_done_o));
  assert_zero_size_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_i && size_q == '0) |=> (!mem_req_o && evt_done_o));
  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_done_o) |-> !mem_req_o);
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int unsigned CH_IDX = 0,
  parameter int unsigned RAW    = 12,
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned SW     = 24
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_valid_i,
  input  logic           reg_write_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic           mem_ack_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           irq_o
);
  localparam int unsigned WIN    = WIN_BASE + WIN_STRIDE * CH_IDX;
  localparam int unsigned BEAT_B = DW / 8;

  logic                 start, abort, size_we, step, busy, evt_done, evt_abort;
  logic [1:0]           mode_we, addr_we, clr;
  logic [1:0][1:0]      side_mode;
  logic [1:0][AW-1:0]   side_addr;
  logic [SW-1:0]        size;

  dma_cmd_decode #(.RAW(RAW), .CH_IDX(CH_IDX)) u_dec (
    .valid_i   (reg_valid_i),
    .write_i   (reg_write_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .busy_i    (busy),
    .start_o   (start),
    .abort_o   (abort),
    .mode_we_o (mode_we),
    .addr_we_o (addr_we),
    .size_we_o (size_we),
    .clr_o     (clr)
  );

  // side 0 = source, side 1 = destination
  for (genvar s = 0; s < 2; s++) begin : g_side
    dma_addr_unit #(.AW(AW), .BEAT_B(BEAT_B)) u_addr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_we_i (mode_we[s]),
      .mode_i    (reg_wdata_i[MODE_LSB+:2]),
      .addr_we_i (addr_we[s]),
      .addr_i    (reg_wdata_i[AW-1:0]),
      .step_i    (step),
      .mode_o    (side_mode[s]),
      .addr_o    (side_addr[s])
    );
  end

  dma_seq #(.AW(AW), .DW(DW), .SW(SW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .abort_i     (abort),
    .size_we_i   (size_we),
    .size_i      (reg_wdata_i[SW-1:0]),
    .clr_i       (clr),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .src_addr_i  (side_addr[0]),
    .dst_addr_i  (side_addr[1]),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .step_o      (step),
    .busy_o      (busy),
    .size_o      (size),
    .evt_done_o  (evt_done),
    .evt_abort_o (evt_abort)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == RAW'(WIN + OFS_EVT)) begin
      reg_rdata_o[EVT_DONE_BIT]  = evt_done;
      reg_rdata_o[EVT_ABORT_BIT] = evt_abort;
    end else if (reg_addr_i == RAW'(WIN + OFS_SMODE)) begin
      reg_rdata_o[MODE_LSB+:2] = side_mode[0];
    end else if (reg_addr_i == RAW'(WIN + OFS_DMODE)) begin
      reg_rdata_o[MODE_LSB+:2] = side_mode[1];
    end else if (reg_addr_i == RAW'(WIN + OFS_SADDR)) begin
      reg_rdata_o = 32'(side_addr[0]);
    end else if (reg_addr_i == RAW'(WIN + OFS_DADDR)) begin
      reg_rdata_o = 32'(side_addr[1]);
    end else if (reg_addr_i == RAW'(WIN + OFS_SIZE)) begin
      reg_rdata_o = 32'(size);
    end
  end

  assign irq_o = evt_done || evt_abort;

  assert_cfg_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !step) |=> ($stable(side_addr) && $stable(side_mode)));
  assert_req_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(start));
endmodule

// File: tb/dma_xfer_engine_test.sv
module dma_xfer_engine_test;
  localparam int CH  = 2;
  localparam int WIN = 'h100 + 'h40 * CH;
  localparam int SWB = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_valid_i = 1'b0, reg_write_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        mem_req_o, mem_we_o, irq_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_xfer_engine #(.CH_IDX(CH), .RAW(12), .AW(32), .DW(32), .SW(SWB)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_valid_i(reg_valid_i), .reg_write_i(reg_write_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [31:0] mem_arr [logic [31:0]];
  logic [31:0] out_q [$];
  int lat = 0, wcnt = 0;
  logic [31:0] fifo_ctr = 0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  always @(negedge clk) begin
    if (mem_ack_i) begin
      mem_ack_i <= 1'b0;
      wcnt = 0;
    end else if (rst_ni && mem_req_o) begin
      if (wcnt >= lat) begin
        mem_ack_i <= 1'b1;
        if (mem_we_o) begin
          if (mem_addr_o[31]) out_q.push_back(mem_wdata_o);
          else mem_arr[mem_addr_o] = mem_wdata_o;
        end else begin
          if (mem_addr_o[31]) begin
            mem_rdata_i <= fifo_ctr;
            fifo_ctr = fifo_ctr + 1;
          end else if (mem_arr.exists(mem_addr_o)) mem_rdata_i <= mem_arr[mem_addr_o];
          else mem_rdata_i <= pat(mem_addr_o);
        end
      end else wcnt++;
    end
  end

  // ---------------- reference model ----------------
  bit          m_busy = 0, m_wr = 0, m_pend = 0, m_done = 0, m_abt = 0;
  logic [1:0]  m_smode = 0, m_dmode = 0;
  logic [31:0] m_src = 0, m_dst = 0, m_buf = 0;
  int          m_size = 0;

  function automatic logic [31:0] stepa(input logic [31:0] a, input logic [1:0] m);
    if (m == 2'd0) return a + 4;
    if (m == 2'd1) return a - 4;
    return a;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_wr = 0; m_pend = 0; m_done = 0; m_abt = 0;
      m_smode = 0; m_dmode = 0; m_src = 0; m_dst = 0; m_buf = 0; m_size = 0;
    end else begin
      bit wr, st, ab, last;
      wr = reg_valid_i && reg_write_i;
      st = wr && reg_addr_i == 0 && reg_wdata_i[CH] && !reg_wdata_i[31];
      ab = wr && reg_addr_i == 0 && reg_wdata_i[CH] && reg_wdata_i[31];
      if (wr && reg_addr_i == WIN + 'h14) begin
        if (reg_wdata_i[1])  m_done = 0;
        if (reg_wdata_i[13]) m_abt = 0;
      end
      if (!m_busy) begin
        if (wr && reg_addr_i == WIN + 'h20) m_smode = reg_wdata_i[5:4];
        if (wr && reg_addr_i == WIN + 'h24) m_dmode = reg_wdata_i[5:4];
        if (wr && reg_addr_i == WIN + 'h28) m_src = reg_wdata_i;
        if (wr && reg_addr_i == WIN + 'h2C) m_dst = reg_wdata_i;
        if (wr && reg_addr_i == WIN + 'h30) m_size = int'(reg_wdata_i[SWB-1:0]);
        if (st) begin
          if (m_size == 0) m_done = 1;
          else begin m_busy = 1; m_wr = 0; end
        end
        if (ab) begin m_done = 1; m_abt = 1; end
      end else begin
        if (ab) m_pend = 1;
        if (!m_wr && mem_ack_i) begin
          m_buf = mem_rdata_i; m_wr = 1;
        end else if (m_wr && mem_ack_i) begin
          last = (m_size <= 4);
          m_src = stepa(m_src, m_smode);
          m_dst = stepa(m_dst, m_dmode);
          m_size = last ? 0 : m_size - 4;
          if (last || m_pend) begin
            m_busy = 0; m_done = 1;
            if (m_pend) m_abt = 1;
            m_pend = 0;
          end
          m_wr = 0;
        end
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [11:0] a);
    if (a == WIN + 'h14) return (32'(m_abt) << 13) | (32'(m_done) << 1);
    if (a == WIN + 'h20) return 32'(m_smode) << 4;
    if (a == WIN + 'h24) return 32'(m_dmode) << 4;
    if (a == WIN + 'h28) return m_src;
    if (a == WIN + 'h2C) return m_dst;
    if (a == WIN + 'h30) return 32'(m_size);
    return 32'h0;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R11 req", 32'(mem_req_o), 32'(m_busy));
      chk("R7 irq", 32'(irq_o), 32'(m_done | m_abt));
      if (m_busy) begin
        chk("R1 dir", 32'(mem_we_o), 32'(m_wr));
        chk("R3 addr", mem_addr_o, m_wr ? m_dst : m_src);
        if (m_wr) chk("R1 wdata", mem_wdata_o, m_buf);
      end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_valid_i = 1; reg_write_i = 1; reg_addr_i = 12'(a); reg_wdata_i = d;
    @(negedge clk);
    reg_valid_i = 0; reg_write_i = 0;
  endtask

  task automatic rd(input string tag, input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr_i = 12'(a);
    #1;
    d = reg_rdata_o;
    chk(tag, d, model_read(12'(a)));
  endtask

  task automatic cfg(input int sm, input int dm, input logic [31:0] s, input logic [31:0] dd, input int n);
    wr(WIN + 'h20, 32'(sm) << 4);
    wr(WIN + 'h24, 32'(dm) << 4);
    wr(WIN + 'h28, s);
    wr(WIN + 'h2C, dd);
    wr(WIN + 'h30, 32'(n));
  endtask

  task automatic go();
    wr(0, 32'(1) << CH);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_evt();
    wr(WIN + 'h14, 32'h0000_2002);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int rem;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // reset state
    rd("R4 size reset", WIN + 'h30, d);
    rd("R5 src reset", WIN + 'h28, d);
    rd("R5 dst reset", WIN + 'h2C, d);
    rd("R7 evt reset", WIN + 'h14, d);
    chk("R7 irq reset", 32'(irq_o), 0);

    // plain incrementing copy, fast memory
    lat = 0;
    cfg(0, 0, 32'h1000, 32'h2000, 16);
    go(); wait_idle();
    for (int k = 0; k < 4; k++)
      chk("R1 copy data", mem_arr[32'h2000 + 4*k], pat(32'h1000 + 4*k));
    chk("R4 no extra beat", 32'(mem_arr.exists(32'h2010)), 0);
    rd("R4 size end", WIN + 'h30, d);
    chk("R4 size zero", d, 0);
    rd("R7 evt done", WIN + 'h14, d);
    chk("R7 done bit", d, 32'h2);
    chk("R7 irq set", 32'(irq_o), 1);
    wr(WIN + 'h14, 32'h2);
    chk("R7 irq cleared", 32'(irq_o), 0);

    // decrementing source, slow memory
    lat = 2;
    cfg(1, 0, 32'h3000, 32'h4000, 12);
    go(); wait_idle();
    for (int k = 0; k < 3; k++)
      chk("R3 dec data", mem_arr[32'h4000 + 4*k], pat(32'h3000 - 4*k));
    rd("R5 src end", WIN + 'h28, d);
    chk("R5 src value", d, 32'h2FF4);
    rd("R5 dst end", WIN + 'h2C, d);
    chk("R5 dst value", d, 32'h400C);
    clear_evt();

    // fixed source (FIFO region)
    lat = 1; fifo_ctr = 100;
    cfg(2, 0, 32'h8000_0000, 32'h5000, 12);
    go(); wait_idle();
    for (int k = 0; k < 3; k++)
      chk("R3 fixed src", mem_arr[32'h5000 + 4*k], 32'(100 + k));
    rd("R3 src held", WIN + 'h28, d);
    chk("R3 src fixed value", d, 32'h8000_0000);
    rd("R3 mode readback", WIN + 'h20, d);
    chk("R3 mode field", d, 32'h20);
    clear_evt();

    // reserved code 3 on destination behaves as fixed
    out_q.delete();
    cfg(0, 3, 32'h6000, 32'h8000_0010, 8);
    go(); wait_idle();
    chk("R3 fifo count", 32'(out_q.size()), 2);
    if (out_q.size() == 2) begin
      chk("R3 fifo w0", out_q[0], pat(32'h6000));
      chk("R3 fifo w1", out_q[1], pat(32'h6004));
    end
    clear_evt();

    // zero size
    cfg(0, 0, 32'h1000, 32'h2100, 0);
    go();
    chk("R10 no request", 32'(mem_req_o), 0);
    rd("R10 evt", WIN + 'h14, d);
    chk("R10 done", d, 32'h2);
    clear_evt();

    // command aimed at another channel
    cfg(0, 0, 32'h1000, 32'h2200, 8);
    wr(0, 32'h1);
    repeat (4) @(negedge clk);
    chk("R2 foreign start", 32'(mem_req_o), 0);
    wr(0, 32'h8000_0001);
    rd("R2 foreign abort", WIN + 'h14, d);
    chk("R2 evt untouched", d, 0);

    // busy: live size, ignored start and config writes
    lat = 3;
    cfg(0, 0, 32'h7000, 32'h7800, 32);
    go();
    repeat (9) @(negedge clk);
    rd("R4 live size", WIN + 'h30, d);
    go();
    wr(WIN + 'h28, 32'hDEAD_0000);
    wr(WIN + 'h30, 32'h4);
    rd("R6 src not loaded", WIN + 'h28, d);
    chk("R6 src not DEAD", 32'(d == 32'hDEAD_0000), 0);
    repeat (7) @(negedge clk);
    rd("R4 live size later", WIN + 'h30, d);
    wait_idle();
    for (int k = 0; k < 8; k++)
      chk("R2 restart ignored", mem_arr[32'h7800 + 4*k], pat(32'h7000 + 4*k));
    chk("R6 size write ignored", 32'(mem_arr.exists(32'h7820)), 0);
    clear_evt();

    // abort mid-transfer
    lat = 2;
    cfg(0, 0, 32'h9000, 32'h9800, 40);
    go();
    repeat (8) @(negedge clk);
    wr(0, 32'h8000_0000 | (32'(1) << CH));
    wait_idle();
    rd("R8 evt", WIN + 'h14, d);
    chk("R8 both flags", d, 32'h2002);
    rd("R8 size left", WIN + 'h30, d);
    rem = int'(d);
    chk("R8 stopped early", 32'(rem > 0 && rem < 40 && rem % 4 == 0), 1);
    chk("R8 last beat done", 32'(mem_arr.exists(32'h9800 + 36 - rem)), 1);
    chk("R8 nothing after", 32'(mem_arr.exists(32'h9800 + 40 - rem)), 0);
    clear_evt();
    chk("R7 clear both", 32'(irq_o), 0);

    // abort while idle, then partial clear
    wr(0, 32'h8000_0000 | (32'(1) << CH));
    rd("R9 evt", WIN + 'h14, d);
    chk("R9 both flags", d, 32'h2002);
    wr(WIN + 'h14, 32'h2000);
    rd("R7 partial clear", WIN + 'h14, d);
    chk("R7 done remains", d, 32'h2);
    chk("R7 irq stays", 32'(irq_o), 1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule